// File: doc/BRIEF.md
# Fault Escalation Controller with NMI Watchdog

This block gathers fault events from on-chip safety monitors and turns them into a graded response for two CPUs. Each fault source is given a class at build time. The lightest class raises a maskable interrupt pulse. The next class latches a non-maskable interrupt and drives a shared external error status pin. The heavier classes request a reset of one CPU only or a warm reset of the whole device. A security-violation flag per CPU requests that CPU's reset directly.

Each CPU has its own NMI watchdog. The watchdog loads a programmable timeout when the NMI latches and counts down once per cycle. An acknowledge from software clears it. If the count runs out without an acknowledge, the response escalates. The primary CPU (index 0) escalates to the device warm reset. The secondary CPU escalates only to its own CPU reset. Reset outputs are fixed-length pulses. After a reset, the state it covers returns to idle.

Top module: `fault_escalator`

## Requirements
- R1: Fault bit `c*NSRC+s` of `fault_i` belongs to CPU `c` and source `s`. With the default classes, source 0 is interrupt class (code 0), source 1 is NMI class (code 1), source 2 is CPU-reset class (code 2) and source 3 is warm-reset class (code 3). When several faults reach one CPU in the same cycle, only the most severe response is applied, so an interrupt-class fault that arrives together with a heavier one raises no interrupt.
- R2: An NMI-class fault on an idle channel sets `nmi_o[c]` on the next cycle, and `err_pin_o` is high in every cycle in which any `nmi_o` bit is high.
- R3: If the primary CPU gives no acknowledge, `warm_rst_o` rises TIMEOUT+1 cycles after `nmi_o[0]` rose, and no CPU reset is raised.
- R4: If the secondary CPU gives no acknowledge, `cpu_rst_o[1]` rises TIMEOUT+1 cycles after `nmi_o[1]` rose, and `warm_rst_o` stays low.
- R5: A security violation on a CPU that is not in reset raises that CPU's `cpu_rst_o` on the next cycle.
- R6: An interrupt-class fault raises `irq_o[c]` for exactly one cycle and never leads to any other response by itself.
- R7: `nmi_ack_i[c]` clears `nmi_o[c]` and the error latch of that CPU on the next edge. An NMI-class fault that arrives while that CPU's NMI is already latched neither reloads nor extends the watchdog.
- R8: Every reset output is a pulse of exactly 8 cycles. While a CPU's reset pulse runs, faults, violations and timeouts of that CPU are ignored.
- R9: A CPU-only reset clears that CPU's NMI but leaves the error pin latched until an acknowledge or a warm reset.
- R10: A warm reset clears all NMI, error and interrupt state at once, and all faults are ignored while it runs. After reset deassertion all outputs are low.
- R11: A CPU-reset-class fault raises only that CPU's `cpu_rst_o`. A warm-reset-class fault from either CPU raises `warm_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_i | input | NCPU*NSRC | Fault events, one bit per CPU and source |
| sec_viol_i | input | NCPU | Security violation flag per CPU |
| nmi_ack_i | input | NCPU | Software acknowledge of NMI per CPU |
| timeout_i | input | TW | Watchdog reload value |
| irq_o | output | NCPU | One-cycle maskable interrupt per CPU |
| nmi_o | output | NCPU | Latched NMI per CPU |
| err_pin_o | output | 1 | External error status pin |
| cpu_rst_o | output | NCPU | CPU-only reset pulse per CPU |
| warm_rst_o | output | 1 | Device warm reset pulse |

## Verification
The bench first applies single-source events of each class on each CPU. This separates the class decode from the channel mapping. Next it applies mixed events in the same cycle, which shows whether the highest severity wins over the lighter ones. Unacknowledged NMIs on the primary and the secondary CPU show the two different escalation targets and the exact expiry cycle. Repeated NMIs, acknowledges, zero timeouts and faults injected during a running reset pulse exercise the latch, reload and blocking rules. A behavioural reference model is compared with every output on every cycle.

// File: rtl/fesc_pkg.sv
package fesc_pkg;

  typedef enum logic [2:0] {
    SEV_NONE   = 3'd0,
    SEV_IRQ    = 3'd1,
    SEV_NMI    = 3'd2,
    SEV_CPURST = 3'd3,
    SEV_WARM   = 3'd4
  } sev_e;

  // two-bit class code of a source mapped onto the severity ladder
  function automatic sev_e class_to_sev(input logic [1:0] cls);
    case (cls)
      2'd0:    return SEV_IRQ;
      2'd1:    return SEV_NMI;
      2'd2:    return SEV_CPURST;
      default: return SEV_WARM;
    endcase
  endfunction

  function automatic sev_e sev_max(input sev_e a, input sev_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fesc_classify.sv
module fesc_classify
  import fesc_pkg::*;
#(
  parameter int                  NSRC  = 4,
  parameter logic [2*NSRC-1:0]   CLASS = '0
) (
  input  logic [NSRC-1:0] fault_i,
  input  logic            sec_i,
  input  logic            blk_i,
  output sev_e            sev_o
);

  sev_e acc;

  always_comb begin
    acc = SEV_NONE;
    for (int s = 0; s < NSRC; s++) begin
      if (fault_i[s]) acc = sev_max(acc, class_to_sev(CLASS[2*s +: 2]));
    end
    if (sec_i) acc = sev_max(acc, SEV_CPURST);
    sev_o = blk_i ? SEV_NONE : acc;
  end

endmodule

// File: rtl/fesc_pulse.sv
module fesc_pulse #(
  parameter int LEN = 8,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (abort_i)      cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_PULSE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !abort_i |=> busy_o); // R8
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i); // R8

endmodule

// File: rtl/fesc_nmi_wdog.sv
module fesc_nmi_wdog #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nmi_ev_i,
  input  logic          ack_i,
  input  logic          blk_i,
  input  logic          wipe_all_i,
  input  logic          wipe_nmi_i,
  input  logic [TW-1:0] timeout_i,
  output logic          nmi_o,
  output logic          err_o,
  output logic          expire_o
);

  logic          nmi_q;
  logic          err_q;
  logic [TW-1:0] wd_q;

  assign expire_o = !blk_i && nmi_q && !ack_i && (wd_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
      err_q <= 1'b0;
      wd_q  <= '0;
    end else if (wipe_all_i) begin
      nmi_q <= 1'b0;
      err_q <= 1'b0;
      wd_q  <= '0;
    end else if (wipe_nmi_i) begin
      nmi_q <= 1'b0;
      wd_q  <= '0;
      if (ack_i) err_q <= 1'b0;
    end else begin
      if (ack_i) err_q <= 1'b0;
      if (nmi_q) begin
        if (ack_i)             nmi_q <= 1'b0;
        else if (wd_q != '0)   wd_q  <= wd_q - 1'b1;
      end else if (nmi_ev_i) begin
        nmi_q <= 1'b1;
        wd_q  <= timeout_i;
        err_q <= 1'b1;
      end
    end
  end

  assign nmi_o = nmi_q;
  assign err_o = err_q;

  AST_ACK_DROPS_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q && ack_i |=> !nmi_q); // R7
  AST_ERR_COVERS_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |-> err_q); // R2
  AST_WD_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ev_i && !nmi_q && !wipe_all_i && !wipe_nmi_i |=> nmi_q && (wd_q == $past(timeout_i))); // R2

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fesc_pkg::*;
#(
  parameter int                NCPU        = 2,
  parameter int                NSRC        = 4,
  parameter logic [2*NSRC-1:0] FAULT_CLASS = {2'd3, 2'd2, 2'd1, 2'd0},
  parameter int                TW          = 16,
  parameter int                RST_LEN     = 8,
  parameter int                PRIMARY     = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCPU*NSRC-1:0] fault_i,
  input  logic [NCPU-1:0]      sec_viol_i,
  input  logic [NCPU-1:0]      nmi_ack_i,
  input  logic [TW-1:0]        timeout_i,
  output logic [NCPU-1:0]      irq_o,
  output logic [NCPU-1:0]      nmi_o,
  output logic                 err_pin_o,
  output logic [NCPU-1:0]      cpu_rst_o,
  output logic                 warm_rst_o
);

  logic [NCPU-1:0] blk;
  logic [NCPU-1:0] expire;
  logic [NCPU-1:0] cpu_req;
  logic [NCPU-1:0] warm_req;
  logic [NCPU-1:0] err_vec;
  logic [NCPU-1:0] irq_q;
  logic            warm_go;
  logic            warm_busy;
  sev_e            sev [NCPU];

  assign warm_go = |warm_req;

  fesc_pulse #(.LEN(RST_LEN)) u_warm_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (warm_go),
    .abort_i (1'b0),
    .busy_o  (warm_busy)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam bit IS_PRIMARY = (c == PRIMARY);
    logic cpu_busy;

    assign blk[c] = warm_busy || cpu_busy;

    fesc_classify #(.NSRC(NSRC), .CLASS(FAULT_CLASS)) u_class (
      .fault_i (fault_i[c*NSRC +: NSRC]),
      .sec_i   (sec_viol_i[c]),
      .blk_i   (blk[c]),
      .sev_o   (sev[c])
    );

    fesc_nmi_wdog #(.TW(TW)) u_wdog (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .nmi_ev_i   (sev[c] == SEV_NMI),
      .ack_i      (nmi_ack_i[c]),
      .blk_i      (blk[c]),
      .wipe_all_i (warm_go),
      .wipe_nmi_i (cpu_req[c]),
      .timeout_i  (timeout_i),
      .nmi_o      (nmi_o[c]),
      .err_o      (err_vec[c]),
      .expire_o   (expire[c])
    );

    if (IS_PRIMARY) begin : g_esc_warm
      assign warm_req[c] = (sev[c] == SEV_WARM) || expire[c];
      assign cpu_req[c]  = (sev[c] == SEV_CPURST) && !warm_go;

      AST_PRIMARY_TO_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire[c] |=> warm_rst_o && !cpu_rst_o[c]); // R3
    end else begin : g_esc_cpu
      assign warm_req[c] = (sev[c] == SEV_WARM);
      assign cpu_req[c]  = ((sev[c] == SEV_CPURST) || expire[c]) && !warm_go;

      AST_SECONDARY_TO_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire[c] |=> cpu_rst_o[c] || warm_rst_o); // R4
    end

    fesc_pulse #(.LEN(RST_LEN)) u_cpu_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (cpu_req[c]),
      .abort_i (warm_go),
      .busy_o  (cpu_busy)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    irq_q[c] <= 1'b0;
      else if (warm_go || cpu_req[c]) irq_q[c] <= 1'b0;
      else                            irq_q[c] <= (sev[c] == SEV_IRQ);
    end

    assign cpu_rst_o[c] = cpu_busy;
    assign irq_o[c]     = irq_q[c];

    AST_SEC_FORCES_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_viol_i[c] && !blk[c] |=> cpu_rst_o[c] || warm_rst_o); // R5
    AST_IRQ_NO_ESCALATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sev[c] == SEV_IRQ) && !warm_go |=> !cpu_rst_o[c] && !nmi_o[c] == !$past(nmi_o[c] && !nmi_ack_i[c])); // R6
  end

  assign err_pin_o  = |err_vec;
  assign warm_rst_o = warm_busy;

  AST_ERR_PIN_ON_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |nmi_o |-> err_pin_o); // R2
  AST_WARM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_o |-> !(|nmi_o) && !err_pin_o && !(|irq_o) && !(|cpu_rst_o)); // R10

endmodule

// File: tb/fault_escalator_tb.sv
module fault_escalator_tb_top;

  localparam int NC = 2;
  localparam int NS = 4;
  localparam int TWB = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NC*NS-1:0] fault;
  logic [NC-1:0]  sec, ack;
  logic [TWB-1:0] tmo;
  logic [NC-1:0]  irq, nmi, crst;
  logic           err, warm;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fault_escalator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fault_i(fault), .sec_viol_i(sec),
    .nmi_ack_i(ack), .timeout_i(tmo), .irq_o(irq), .nmi_o(nmi),
    .err_pin_o(err), .cpu_rst_o(crst), .warm_rst_o(warm)
  );

  // ---------------- behavioural reference ----------------
  int m_nmi[NC], m_wd[NC], m_err[NC], m_rc[NC], m_irq[NC];
  int m_wc;

  always @(posedge clk) begin
    int sv[NC];
    int ex[NC];
    int creq[NC];
    int wreq;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_nmi[c] = 0; m_wd[c] = 0; m_err[c] = 0; m_rc[c] = 0; m_irq[c] = 0;
      end
      m_wc = 0;
    end else begin
      wreq = 0;
      for (int c = 0; c < NC; c++) begin
        bit bl;
        bl = (m_wc > 0) || (m_rc[c] > 0);
        sv[c] = 0;
        if (!bl) begin
          for (int s = 0; s < NS; s++) if (fault[c*NS+s] && s + 1 > sv[c]) sv[c] = s + 1;
          if (sec[c] && sv[c] < 3) sv[c] = 3;
        end
        ex[c]   = (!bl && m_nmi[c] != 0 && !ack[c] && m_wd[c] == 0) ? 1 : 0;
        creq[c] = (!bl && (sv[c] == 3 || (ex[c] != 0 && c != 0))) ? 1 : 0;
        if (!bl && (sv[c] == 4 || (ex[c] != 0 && c == 0))) wreq = 1;
      end
      if (wreq != 0) m_wc = 8; else if (m_wc > 0) m_wc--;
      for (int c = 0; c < NC; c++) begin
        if (wreq != 0) begin
          m_nmi[c] = 0; m_wd[c] = 0; m_err[c] = 0; m_rc[c] = 0; m_irq[c] = 0;
        end else if (creq[c] != 0) begin
          m_nmi[c] = 0; m_wd[c] = 0; m_rc[c] = 8; m_irq[c] = 0;
          if (ack[c]) m_err[c] = 0;
        end else begin
          if (m_rc[c] > 0) m_rc[c]--;
          m_irq[c] = (sv[c] == 1) ? 1 : 0;
          if (ack[c]) m_err[c] = 0;
          if (m_nmi[c] != 0) begin
            if (ack[c]) m_nmi[c] = 0; else if (m_wd[c] > 0) m_wd[c]--;
          end else if (sv[c] == 2) begin
            m_nmi[c] = 1; m_wd[c] = int'(tmo); m_err[c] = 1;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        chk("R6 model irq",  int'(irq[c]),  m_irq[c]);
        chk("R7 model nmi",  int'(nmi[c]),  m_nmi[c]);
        chk("R8 model crst", int'(crst[c]), (m_rc[c] > 0) ? 1 : 0);
      end
      chk("R2 model err",  int'(err),  (m_err[0] + m_err[1] > 0) ? 1 : 0);
      chk("R3 model warm", int'(warm), (m_wc > 0) ? 1 : 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(input int bitn);
    fault = '0; fault[bitn] = 1'b1;
    @(negedge clk);
    fault = '0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; fault = '0; sec = '0; ack = '0; tmo = 16'd5;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset state", int'({irq, nmi, err, crst, warm}), 0);

    // R6: interrupt class pulse on CPU0
    pulse_in(0);
    chk("R6 irq raised", int'(irq[0]), 1);
    chk("R6 no nmi", int'(nmi[0]), 0);
    @(negedge clk);
    chk("R6 irq one cycle", int'(irq[0]), 0);
    idle(2);
    chk("R6 no escalation", int'({crst, warm}), 0);

    // R1: IRQ and NMI together on CPU1 -> NMI only
    fault = '0; fault[4] = 1'b1; fault[5] = 1'b1;
    @(negedge clk); fault = '0;
    chk("R1 irq suppressed", int'(irq[1]), 0);
    chk("R1 nmi wins", int'(nmi[1]), 1);
    chk("R2 err with nmi", int'(err), 1);
    idle(2);
    ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
    chk("R7 ack clears nmi", int'(nmi[1]), 0);
    chk("R7 ack clears err", int'(err), 0);

    // R1: NMI + CPU-reset class together on CPU0
    fault = '0; fault[1] = 1'b1; fault[2] = 1'b1;
    @(negedge clk); fault = '0;
    chk("R1 reset wins", int'(crst[0]), 1);
    chk("R1 nmi not latched", int'(nmi[0]), 0);
    idle(10);

    // R3: primary timeout -> warm reset after TIMEOUT+1 cycles
    pulse_in(1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R3 warm not early", int'(warm), 0);
    end
    @(negedge clk);
    chk("R3 warm on expiry", int'(warm), 1);
    chk("R3 no cpu reset", int'(crst[0]), 0);
    chk("R10 nmi cleared by warm", int'(nmi[0]), 0);
    for (int i = 0; i < 7; i++) @(negedge clk);
    chk("R8 warm still high at 8", int'(warm), 1);
    @(negedge clk);
    chk("R8 warm 8 cycles", int'(warm), 0);
    idle(2);

    // R4 / R9: secondary timeout -> own CPU reset only
    pulse_in(5);
    idle(5);
    @(negedge clk);
    chk("R4 cpu1 reset", int'(crst[1]), 1);
    chk("R4 no warm", int'(warm), 0);
    chk("R9 err kept", int'(err), 1);
    chk("R9 nmi cleared", int'(nmi[1]), 0);
    pulse_in(7);
    chk("R8 fault ignored in reset", int'(warm), 0);
    idle(8);
    chk("R8 cpu reset ended", int'(crst[1]), 0);
    chk("R9 err after cpu reset", int'(err), 1);
    ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
    chk("R9 ack clears err", int'(err), 0);

    // R5: security violation
    sec[0] = 1'b1; @(negedge clk); sec[0] = 1'b0;
    chk("R5 cpu0 reset", int'(crst[0]), 1);
    chk("R5 cpu1 untouched", int'(crst[1]), 0);
    idle(10);

    // R11: class-driven resets
    pulse_in(2);
    chk("R11 cpu reset class", int'(crst[0]), 1);
    chk("R11 no warm", int'(warm), 0);
    idle(10);
    pulse_in(7);
    chk("R11 warm class from cpu1", int'(warm), 1);
    pulse_in(1);
    idle(8);
    chk("R10 nmi ignored in warm", int'(nmi[0]), 0);
    idle(2);

    // R7: repeated NMI does not reload the watchdog
    pulse_in(1);
    idle(2);
    pulse_in(1);
    idle(3);
    chk("R7 no reload", int'(warm), 1);
    idle(10);

    // R7: zero timeout, acknowledge in time
    tmo = 16'd0;
    pulse_in(5);
    ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
    chk("R7 zero timeout acked", int'(nmi[1]), 0);
    chk("R7 no reset after ack", int'(crst[1]), 0);
    idle(4);
    tmo = 16'd3;
    pulse_in(1);
    idle(3);
    @(negedge clk);
    chk("R3 short timeout", int'(warm), 1);
    idle(12);

    finish_run();
  end

endmodule